// File: doc/BRIEF.md
# Pipelined Burst SRAM Access Controller

This block is a synchronous single-port memory with one shared data path for reads and writes. It holds a small array of byte-laned words and decides at each rising clock edge whether the cycle is a read, a write, a deselect or nothing. The decision is based on two address strobes, three chip selects, a global write enable, a byte write enable and per-lane byte selects. One strobe is meant for a processor and one for a cache controller. The two strobes differ in how they treat writes. A processor-strobe access always begins as a read and can turn into a write on the following edge. A controller-strobe write completes on the edge where it starts.

Read data moves through a pipeline. The address is registered on one edge, and the word reaches the registered output on the next edge. The bidirectional bus is modelled as an input word, an output word and an output-enable flag. The output enable follows the output-enable pin without a clock. It is also gated by internal rules that turn the drivers off around deselects, writes and reselection. After a strobe, further cycles with both strobes high continue the burst at a captured base address. The 2-bit offset is sequenced in either linear or interleaved order.

Top module: `sram_burst_ctrl`

## Requirements
- R1: While reset is low at a clock edge (synchronous, active low), the block becomes deselected, `dout_en` goes low and `dout` is cleared to zero.
- R2: A read begins at an edge where a strobe starts an access with all chip selects active (`cs1_n`=0, `cs2`=1, `cs3_n`=0) and both `wr_all_n` and `wr_byte_n` are high. A continuation cycle with no write enable low is also a read. The word at the read address appears on `dout` after the following edge, and `dout_en` is high from then on while `oe_n` is low.
- R3: When `cs1_n` is high, `pstb_n` is ignored. With `cstb_n` high in that case, a deselected block stays deselected.
- R4: In the cycle after an access starts from the deselected state, `dout_en` is low whatever `oe_n` is.
- R5: At an edge where any chip select is inactive and a strobe that is not ignored is low, the block deselects. `dout_en` is low in the cycle that follows.
- R6: A processor-strobe access ignores the write enables and `adv_n` on its first edge and reads there. If a write enable is low on the next edge (both strobes high), `din` is written at the captured address on that edge.
- R7: A controller-strobe access with `pstb_n` high or ignored, chip selects active and a write enable low writes `din` on that same edge.
- R8: When both strobes are low at an edge with chip selects active, the processor-strobe access wins. That edge is a read and no write happens.
- R9: With `wr_all_n` low, all lanes are written whatever `wr_byte_n` and `lane_sel_n` hold. Lane i is `din[8i+7:8i]`.
- R10: With `wr_all_n` high and `wr_byte_n` low, only lanes whose `lane_sel_n[i]` is low are written. The other lanes keep their contents.
- R11: In the cycle after any write edge, `dout_en` is low whatever `oe_n` is.
- R12: `oe_n` high forces `dout_en` low in the same cycle, with no clock edge involved.
- R13: At a continuation edge (both strobes high, block selected), the effective address is the base with its two low bits replaced by the burst term. The burst term is base+count mod 4 when `burst_lin`=1 and base XOR count when it is 0. `adv_n` low increments the 2-bit count first. `adv_n` high keeps it unchanged, so the same address is used again. A strobe access sets the base to `addr` and the count to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pstb_n | input | 1 | Processor address strobe, active low |
| cstb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| cs1_n | input | 1 | Chip select 1, active low; also gates `pstb_n` |
| cs2 | input | 1 | Chip select 2, active high |
| cs3_n | input | 1 | Chip select 3, active low |
| burst_lin | input | 1 | 1 selects linear burst order, 0 interleaved |
| wr_all_n | input | 1 | Global write enable, active low |
| wr_byte_n | input | 1 | Byte write enable, active low |
| lane_sel_n | input | 4 | Per-lane byte selects, active low |
| addr | input | 6 | Word address |
| oe_n | input | 1 | Output enable, active low, combinational |
| din | input | 32 | Write data (bus input side) |
| dout | output | 32 | Registered read data (bus output side) |
| dout_en | output | 1 | Bus driver enable |

## Verification
A wrong cycle decision or wrong burst state shows up as a wrong word on `dout` one edge after the bad read is issued. A silent bad write shows up later, on the first read of that address. A mistake in the driver-enable state shows up in the very next cycle as `dout_en` high where a deselect, write or reselection should have forced it low. A missing enable shows up the same way. The bench therefore prefills the whole array, compares bus enable and data every cycle against an independent cycle model, and steers directed bursts so that linear and interleaved orders visit different addresses.

// File: rtl/sram_ctrl_pkg.sv
// Package: shared cycle encoding for the burst SRAM controller.
// Assumes: consumers import it; no state lives here.
package sram_ctrl_pkg;

    // Kind of cycle decided at a clock edge.
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_DESEL = 2'd1,
        CYC_READ  = 2'd2,
        CYC_WRITE = 2'd3
    } cyc_e;

endpackage

// File: rtl/sram_cyc_dec.sv
// Module: sram_cyc_dec
// Decodes strobes, chip selects and write enables into the cycle kind for
// the current edge, plus address-load and burst-advance requests and the
// lane write mask.
// Assumes: inputs are stable around the clock edge; sel_q is the selected flag
// held by the top level.
module sram_cyc_dec
    import sram_ctrl_pkg::*;
#(
    parameter int NB = 4
) (
    input  logic          pstb_n,
    input  logic          cstb_n,
    input  logic          adv_n,
    input  logic          cs1_n,
    input  logic          cs2,
    input  logic          cs3_n,
    input  logic          wr_all_n,
    input  logic          wr_byte_n,
    input  logic [NB-1:0] lane_sel_n,
    input  logic          sel_q,
    output cyc_e          cyc,
    output logic          load,
    output logic          adv,
    output logic [NB-1:0] lane_en
);

    logic pstart;
    logic cs_ok;
    logic any_wr;

    // Processor strobe counts only while chip select 1 is active.
    assign pstart = !pstb_n && !cs1_n;
    assign cs_ok  = !cs1_n && cs2 && !cs3_n;
    assign any_wr = !wr_all_n || !wr_byte_n;

    // Global write covers every lane, otherwise the selected lanes only.
    assign lane_en = !wr_all_n ? {NB{1'b1}} : (wr_byte_n ? '0 : ~lane_sel_n);

    // Cycle priority: deselect, processor start, controller start, continuation.
    always_comb begin
        cyc  = CYC_IDLE;
        load = 1'b0;
        adv  = 1'b0;
        if ((pstart || !cstb_n) && !cs_ok) begin
            cyc = CYC_DESEL;
        end else if (pstart) begin
            cyc  = CYC_READ;
            load = 1'b1;
        end else if (!cstb_n) begin
            cyc  = any_wr ? CYC_WRITE : CYC_READ;
            load = 1'b1;
        end else if (sel_q) begin
            cyc = any_wr ? CYC_WRITE : CYC_READ;
            adv = !adv_n;
        end
    end

endmodule

// File: rtl/sram_burst_addr.sv
// Module: sram_burst_addr
// Holds the burst base address and the 2-bit wrap-around count, and gives the
// effective address used at the current edge (linear or interleaved order).
// Assumes: AW > 2; load and adv are never both high.
module sram_burst_addr #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    input  logic          mode_lin,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] cur_ea
);

    logic [AW-1:0] base_q;
    logic [1:0]    cnt_q;
    logic [1:0]    cnt_nxt;
    logic [1:0]    low_bits;

    // Count used at this edge: advanced first when requested.
    assign cnt_nxt  = adv ? cnt_q + 2'd1 : cnt_q;
    assign low_bits = mode_lin ? (base_q[1:0] + cnt_nxt) : (base_q[1:0] ^ cnt_nxt);
    assign cur_ea   = load ? addr_in : {base_q[AW-1:2], low_bits};

    // Capture base on a strobe, step the count on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            base_q <= addr_in;
            cnt_q  <= '0;
        end else if (adv) begin
            cnt_q <= cnt_nxt;
        end
    end

    AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> ($stable(cnt_q) && $stable(base_q))) else $error("burst state moved without request"); // R13

    AST_BURST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == 2'd0)) else $error("count not cleared on load"); // R13

endmodule

// File: rtl/sram_byte_array.sv
// Module: sram_byte_array
// Word memory built from independent byte lanes, with a per-lane write
// strobe and an asynchronous read port that feeds the output register.
// Assumes: contents are not reset; one write per edge.
module sram_byte_array #(
    parameter int DEPTH  = 64,
    parameter int AW     = 6,
    parameter int NB     = 4,
    parameter int BYTE_W = 8
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [NB-1:0]        lane_en,
    input  logic [AW-1:0]        waddr,
    input  logic [NB*BYTE_W-1:0] wdata,
    input  logic [AW-1:0]        raddr,
    output logic [NB*BYTE_W-1:0] rdata
);

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH];

        // Write this lane when the cycle writes and the lane is enabled.
        always_ff @(posedge clk) begin
            if (we && lane_en[g]) begin
                lane_mem[waddr] <= wdata[g*BYTE_W +: BYTE_W];
            end
        end

        assign rdata[g*BYTE_W +: BYTE_W] = lane_mem[raddr];
    end

endmodule

// File: rtl/sram_burst_ctrl.sv
// Module: sram_burst_ctrl (top)
// Synchronous common-I/O SRAM with two address strobes, burst sequencing,
// byte writes and a pipelined, registered read path. The output enable is
// gated by oe_n and by internal conditions that force three-state.
// Assumes: single clock domain, synchronous active-low reset.
module sram_burst_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int NB     = 4,
    parameter int BYTE_W = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int DW    = NB * BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pstb_n,
    input  logic          cstb_n,
    input  logic          adv_n,
    input  logic          cs1_n,
    input  logic          cs2,
    input  logic          cs3_n,
    input  logic          burst_lin,
    input  logic          wr_all_n,
    input  logic          wr_byte_n,
    input  logic [NB-1:0] lane_sel_n,
    input  logic [AW-1:0] addr,
    input  logic          oe_n,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_en
);

    cyc_e          cyc;
    logic          load;
    logic          adv;
    logic [NB-1:0] lane_en;
    logic [AW-1:0] cur_ea;
    logic [DW-1:0] rdata;

    logic          sel_q;
    logic          rd_q;
    logic          drv_q;
    logic [AW-1:0] ea_q;

    sram_cyc_dec #(.NB(NB)) u_dec (
        .pstb_n     (pstb_n),
        .cstb_n     (cstb_n),
        .adv_n      (adv_n),
        .cs1_n      (cs1_n),
        .cs2        (cs2),
        .cs3_n      (cs3_n),
        .wr_all_n   (wr_all_n),
        .wr_byte_n  (wr_byte_n),
        .lane_sel_n (lane_sel_n),
        .sel_q      (sel_q),
        .cyc        (cyc),
        .load       (load),
        .adv        (adv),
        .lane_en    (lane_en)
    );

    sram_burst_addr #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .adv      (adv),
        .mode_lin (burst_lin),
        .addr_in  (addr),
        .cur_ea   (cur_ea)
    );

    sram_byte_array #(.DEPTH(DEPTH), .AW(AW), .NB(NB), .BYTE_W(BYTE_W)) u_mem (
        .clk     (clk),
        .we      (cyc == CYC_WRITE),
        .lane_en (lane_en),
        .waddr   (cur_ea),
        .wdata   (din),
        .raddr   (ea_q),
        .rdata   (rdata)
    );

    // Selection, read pipeline and driver-enable state per edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
            rd_q  <= 1'b0;
            drv_q <= 1'b0;
            ea_q  <= '0;
            dout  <= '0;
        end else begin
            if (rd_q) begin
                dout <= rdata;
            end
            unique case (cyc)
                CYC_DESEL: begin
                    sel_q <= 1'b0;
                    rd_q  <= 1'b0;
                    drv_q <= 1'b0;
                end
                CYC_READ: begin
                    sel_q <= 1'b1;
                    rd_q  <= 1'b1;
                    ea_q  <= cur_ea;
                    drv_q <= rd_q;
                end
                CYC_WRITE: begin
                    sel_q <= 1'b1;
                    rd_q  <= 1'b0;
                    drv_q <= 1'b0;
                end
                default: begin
                    rd_q  <= 1'b0;
                    drv_q <= 1'b0;
                end
            endcase
        end
    end

    assign dout_en = drv_q && !oe_n;

    AST_DESEL_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_DESEL) |=> !dout_en) else $error("driving after deselect"); // R5

    AST_WRITE_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_WRITE) |=> !dout_en) else $error("driving after write"); // R11

    AST_RESEL_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_q && (cyc == CYC_READ || cyc == CYC_WRITE)) |=> !dout_en) else $error("driving on reselect cycle"); // R4

    AST_PSTB_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (cs1_n && cstb_n && !sel_q) |=> !sel_q) else $error("processor strobe not gated"); // R3

endmodule

// File: tb/tb_sram_burst_ctrl.sv
module tb_sram_burst_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;
    localparam int AW = 6;
    localparam int NB = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          pstb_n, cstb_n, adv_n, cs1_n, cs2, cs3_n, burst_lin;
    logic          wr_all_n, wr_byte_n, oe_n;
    logic [NB-1:0] lane_sel_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] din;
    logic [DW-1:0] dout;
    logic          dout_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    string tag = "R1";

    // Reference model state
    logic [DW-1:0] ref_mem [DEPTH];
    logic          m_sel, m_rd, m_drv;
    logic [AW-1:0] m_base, m_ea;
    logic [1:0]    m_cnt;
    logic [DW-1:0] m_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_burst_ctrl dut (
        .clk(clk), .rst_n(rst_n), .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n),
        .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .burst_lin(burst_lin),
        .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_sel_n(lane_sel_n),
        .addr(addr), .oe_n(oe_n), .din(din), .dout(dout), .dout_en(dout_en)
    );

    function automatic logic [AW-1:0] burst_ea(input logic [AW-1:0] b, input logic [1:0] c,
                                               input logic lin);
        logic [1:0] lo;
        lo = lin ? (b[1:0] + c) : (b[1:0] ^ c);
        return {b[AW-1:2], lo};
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                            input logic [NB-1:0] en);
        logic [DW-1:0] r;
        r = old;
        for (int i = 0; i < NB; i++) if (en[i]) r[i*8 +: 8] = nw[i*8 +: 8];
        return r;
    endfunction

    task automatic model_write(input logic [AW-1:0] a);
        logic [NB-1:0] en;
        en = !wr_all_n ? {NB{1'b1}} : (wr_byte_n ? '0 : ~lane_sel_n);
        ref_mem[a] = merge(ref_mem[a], din, en);
    endtask

    // Update the model with the inputs seen at the edge just taken.
    task automatic model_edge();
        logic sp, cs, wr;
        logic [DW-1:0] nout;
        logic [1:0] c;
        if (!rst_n) begin
            m_sel = 0; m_rd = 0; m_drv = 0; m_base = '0; m_cnt = '0; m_ea = '0; m_out = '0;
            return;
        end
        sp = !pstb_n && !cs1_n;
        cs = !cs1_n && cs2 && !cs3_n;
        wr = !wr_all_n || !wr_byte_n;
        nout = m_rd ? ref_mem[m_ea] : m_out;
        if ((sp || !cstb_n) && !cs) begin
            m_sel = 0; m_rd = 0; m_drv = 0;
        end else if (sp) begin
            m_sel = 1; m_base = addr; m_cnt = 0; m_ea = addr; m_drv = m_rd; m_rd = 1;
        end else if (!cstb_n) begin
            m_sel = 1; m_base = addr; m_cnt = 0;
            if (wr) begin model_write(addr); m_rd = 0; m_drv = 0; end
            else begin m_ea = addr; m_drv = m_rd; m_rd = 1; end
        end else if (m_sel) begin
            c = adv_n ? m_cnt : m_cnt + 2'd1;
            m_cnt = c;
            if (wr) begin model_write(burst_ea(m_base, c, burst_lin)); m_rd = 0; m_drv = 0; end
            else begin m_ea = burst_ea(m_base, c, burst_lin); m_drv = m_rd; m_rd = 1; end
        end else begin
            m_rd = 0; m_drv = 0;
        end
        m_out = nout;
    endtask

    task automatic check_bus();
        logic exp_en;
        exp_en = m_drv && !oe_n;
        n_chk++;
        if (dout_en !== exp_en || (exp_en && dout !== m_out)) begin
            n_fail++;
            $display("FAIL %s: dout_en=%b dout=%h expected dout_en=%b dout=%h",
                     tag, dout_en, dout, exp_en, m_out);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_bus();
    endtask

    task automatic idle();
        pstb_n = 1; cstb_n = 1; adv_n = 1; cs1_n = 0; cs2 = 1; cs3_n = 0;
        wr_all_n = 1; wr_byte_n = 1; lane_sel_n = '1; oe_n = 0;
    endtask

    task automatic c_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        idle(); cstb_n = 0; addr = a; din = d; wr_all_n = 0; cyc();
    endtask

    task automatic c_read(input logic [AW-1:0] a);
        idle(); cstb_n = 0; addr = a; cyc();
    endtask

    task automatic deselect();
        idle(); cstb_n = 0; cs2 = 0; cyc();
    endtask

    initial begin
        rst_n = 0; idle(); burst_lin = 1; addr = '0; din = '0;
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        repeat (3) cyc();
        // R1: reset state
        n_chk++;
        if (dout_en !== 1'b0 || dout !== '0) begin
            n_fail++;
            $display("FAIL R1: dout_en=%b dout=%h expected dout_en=0 dout=0", dout_en, dout);
        end
        rst_n = 1;
        tag = "R1"; idle(); cyc();

        // R7 and R9: fill whole array with controller-strobe global writes
        tag = "R7";
        for (int i = 0; i < DEPTH; i++) c_write(i[AW-1:0], 32'hA500_0000 + i * 32'h0101_0301);
        tag = "R9"; idle(); cstb_n = 0; addr = 6'd9; din = 32'h1122_3344;
        wr_all_n = 0; wr_byte_n = 0; lane_sel_n = 4'b1111; cyc();

        // R2: reads, pipelined
        tag = "R2"; c_read(6'd9); c_read(6'd3); idle(); cyc(); cyc(); deselect();

        // R10: byte write lanes 0 and 2 only
        tag = "R10"; idle(); cstb_n = 0; addr = 6'd5; din = 32'hDEAD_BEEF;
        wr_byte_n = 0; lane_sel_n = 4'b1010; cyc();
        c_read(6'd5); idle(); cyc(); deselect();

        // R6: processor write, enables ignored on first edge
        tag = "R6"; idle(); pstb_n = 0; addr = 6'd6; wr_all_n = 0; din = 32'h0BAD_F00D; adv_n = 0; cyc();
        idle(); wr_all_n = 0; din = 32'h600D_CAFE; cyc();
        c_read(6'd6); idle(); cyc(); deselect();

        // R8: both strobes low, processor wins, no write
        tag = "R8"; idle(); pstb_n = 0; cstb_n = 0; addr = 6'd7; wr_all_n = 0; din = '1; cyc();
        idle(); cyc(); idle(); cyc(); deselect();

        // R13: linear then interleaved burst from base 1
        tag = "R13"; idle(); burst_lin = 1; pstb_n = 0; addr = 6'd1; cyc();
        for (int k = 0; k < 4; k++) begin idle(); adv_n = 0; cyc(); end
        idle(); cyc(); deselect();
        idle(); burst_lin = 0; pstb_n = 0; addr = 6'd13; cyc();
        for (int k = 0; k < 4; k++) begin idle(); adv_n = 0; cyc(); end
        idle(); cyc(); deselect(); burst_lin = 1;

        // R4: reselect after deselect, first cycle three-stated
        tag = "R4"; c_read(6'd20); idle(); cyc(); deselect();
        // R5: deselect via each select
        tag = "R5"; c_read(6'd21); idle(); cyc(); idle(); pstb_n = 0; cs3_n = 1; cyc(); idle(); cyc();
        c_read(6'd22); idle(); cyc(); idle(); cstb_n = 0; cs1_n = 1; cyc(); idle(); cyc();
        // R3: processor strobe ignored with cs1_n high
        tag = "R3"; idle(); pstb_n = 0; cs1_n = 1; addr = 6'd2; cyc(); idle(); cyc(); cyc();
        // R11: read then continuation write
        tag = "R11"; c_read(6'd30); idle(); cyc(); idle(); wr_byte_n = 0; lane_sel_n = 4'b0111;
        din = 32'h7700_0000; cyc(); idle(); cyc(); idle(); cyc(); deselect();
        // R12: oe_n high hides valid data
        tag = "R12"; c_read(6'd31); idle(); cyc(); idle(); oe_n = 1; cyc(); idle(); cyc(); deselect();

        // Constrained random phase, fixed seed
        tag = "R2 random";
        void'($urandom(32'd1234));
        for (int n = 0; n < 3000; n++) begin
            pstb_n     = ($urandom_range(0, 9) != 0);
            cstb_n     = ($urandom_range(0, 5) != 0);
            adv_n      = $urandom_range(0, 1);
            cs1_n      = ($urandom_range(0, 9) == 0);
            cs2        = ($urandom_range(0, 11) != 0);
            cs3_n      = ($urandom_range(0, 11) == 0);
            burst_lin  = $urandom_range(0, 1);
            wr_all_n   = ($urandom_range(0, 7) != 0);
            wr_byte_n  = ($urandom_range(0, 4) != 0);
            lane_sel_n = 4'($urandom);
            oe_n       = ($urandom_range(0, 6) == 0);
            addr       = 6'($urandom);
            din        = $urandom;
            cyc();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule